// File: doc/BRIEF.md
# Dual-Port Encoder Interrupt Controller

This block gathers single-cycle event pulses from a rotary-encoder front end into an eight-bit sticky status word. It drives two active-high interrupt lines, each gated by its own set of enable bits. The sources are two target-position matches, a gate-time tick, an index mark, two counter overflows and a rotation-direction check. The direction check is done once for each port. Every count step carries a direction flag. A step whose direction differs from the direction programmed for a port raises that port's own wrong-direction status bit.

A host reaches the block over a small synchronous register bus with two 16-bit control words and the status word. Reading the status word returns its contents and clears them. An event that lands in the same cycle as the clearing read is kept. A host with an 8-bit bus sets `byte_mode_i`. It then reaches each 16-bit register as two bytes: the low byte at the even address, written first and held in a staging register, then the high byte at the odd address, which commits the whole word.

Top module: `irqc_top`

## Requirements
- R1: A synchronous active-low reset clears both control words, the status word, the staging register and the read data, and holds both interrupt outputs low.
- R2: Each event sets its status bit: bit 0 target 1, bit 1 target 2, bit 2 gate tick, bit 3 index, bit 4 wrong direction for port 1, bit 5 wrong direction for port 2, bit 6 overflow 1, bit 7 overflow 2. A set bit stays set until the status word is read.
- R3: A step pulse sets bit 4 when its direction flag (1 = counter-clockwise) differs from control word 1 bit 1. It sets bit 5 when the flag differs from control word 1 bit 12. A step matching the programmed direction sets nothing.
- R4: A read of the status address (0x04) returns the status in bits 7:0 and clears it. An event arriving in the clearing cycle is not in the returned value and remains set afterwards.
- R5: `irq1_o` is high while any of these is set together with its enable in control word 1: target 1 with bit 0, gate tick with bit 2, port-1 wrong direction with bit 3, index with bit 4, target 2 with bit 5.
- R6: `irq2_o` is high while any of these is set together with its enable: target 2 with bit 10, target 1 with bit 11, port-2 wrong direction with bit 13, index with bit 14, gate tick with bit 15.
- R7: The overflow bits (6, 7) never raise either interrupt output.
- R8: In word mode control word 1 (address 0x00) and control word 2 (address 0x02) are written and read as whole words. A word write to an odd address is ignored, and a word read of an odd address returns zero.
- R9: In byte mode a write to the even address only stages the low byte. The register keeps its old value until the following high-byte write to the odd address of the same register commits both bytes at once.
- R10: In byte mode a high-byte write with no low byte staged for that same register is ignored and leaves the register unchanged.
- R11: In byte mode a read of the even address returns the low byte and a read of the odd address returns the high byte, both in bits 7:0 with bits 15:8 zero. An odd-address status read does not clear the status.
- R12: `rdata_o` is registered. It shows the addressed value one cycle after the read strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_mode_i | input | 1 | 1 = 8-bit host, byte-wise access |
| cs_i | input | 1 | Bus select |
| wr_i | input | 1 | Write strobe (with cs_i) |
| rd_i | input | 1 | Read strobe (with cs_i) |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 16 | Write data (bits 7:0 in byte mode) |
| rdata_o | output | 16 | Registered read data |
| evt_tgt1_i | input | 1 | Target 1 reached pulse |
| evt_tgt2_i | input | 1 | Target 2 reached pulse |
| evt_tick_i | input | 1 | Gate-time tick pulse |
| evt_idx_i | input | 1 | Index mark pulse |
| evt_ovf1_i | input | 1 | Overflow 1 pulse |
| evt_ovf2_i | input | 1 | Overflow 2 pulse |
| step_i | input | 1 | Count step pulse |
| step_ccw_i | input | 1 | Direction of the step, 1 = counter-clockwise |
| irq1_o | output | 1 | Interrupt port 1, active high |
| irq2_o | output | 1 | Interrupt port 2, active high |

## Verification
An event pulse held across one rising edge is in the status word and on the interrupt outputs right after that edge, because the outputs are combinational from the latched status. A register write takes effect at the edge that samples it. Read data and the status clear both appear one edge after the read strobe. The bench drives every stimulus on a falling edge, leaves it for exactly one rising edge and samples on the next falling edge, so each result is read in the first half-cycle in which it is due. The same-cycle event-and-read case is driven inside one strobe window, so the returned value and the surviving bit are both compared at that same point.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the dual-port interrupt controller.
// Holds the status bit layout, the register addresses and the per-port
// enable map taken from control word 1. Assumes a 16-bit data path.
package irqc_pkg;

    localparam int DW     = 16;
    localparam int BW     = DW / 2;
    localparam int ADDR_W = 5;
    localparam int NSRC   = 8;
    localparam int NPORT  = 2;

    // status bit positions
    localparam int ST_TGT1 = 0;
    localparam int ST_TGT2 = 1;
    localparam int ST_TICK = 2;
    localparam int ST_IDX  = 3;
    localparam int ST_WD1  = 4;
    localparam int ST_WD2  = 5;
    localparam int ST_OVF1 = 6;
    localparam int ST_OVF2 = 7;

    localparam logic [NSRC-1:0] OVF_MASK = 8'hC0;

    // control word 1 direction bits (1 = counter-clockwise expected)
    localparam int CW_DIR1 = 1;
    localparam int CW_DIR2 = 12;

    // byte addresses (words on even addresses)
    localparam logic [ADDR_W-1:0] A_CW1  = 5'h00;
    localparam logic [ADDR_W-1:0] A_CW2  = 5'h02;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h04;

    typedef enum logic [1:0] {
        STG_NONE = 2'd0,
        STG_CW1  = 2'd1,
        STG_CW2  = 2'd2
    } stage_tgt_e;

    // Enable mask of one interrupt port, picked out of control word 1.
    function automatic logic [NSRC-1:0] port_mask(input int port, input logic [DW-1:0] cw);
        logic [NSRC-1:0] m;
        m = '0;
        if (port == 0) begin
            m[ST_TGT1] = cw[0];
            m[ST_TICK] = cw[2];
            m[ST_WD1]  = cw[3];
            m[ST_IDX]  = cw[4];
            m[ST_TGT2] = cw[5];
        end else begin
            m[ST_TGT2] = cw[10];
            m[ST_TGT1] = cw[11];
            m[ST_WD2]  = cw[13];
            m[ST_IDX]  = cw[14];
            m[ST_TICK] = cw[15];
        end
        return m;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
// Register bank: decodes the host bus, holds both control words, stages
// byte-mode low bytes, builds the registered read data and issues the
// status clear strobe. Assumes single-cycle strobes qualified by cs_i.
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode_i,
    input  logic              cs_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NSRC-1:0]   status_i,
    output logic [DW-1:0]     cw1_o,
    output logic [DW-1:0]     cw2_o,
    output logic              stat_clr_o,
    output logic [DW-1:0]     rdata_o
);

    localparam logic [ADDR_W-2:0] W_CW1  = A_CW1[ADDR_W-1:1];
    localparam logic [ADDR_W-2:0] W_CW2  = A_CW2[ADDR_W-1:1];
    localparam logic [ADDR_W-2:0] W_STAT = A_STAT[ADDR_W-1:1];

    logic [DW-1:0]     cw1_q, cw2_q, rdata_q;
    logic [BW-1:0]     stage_q;
    stage_tgt_e        stage_tgt_q;
    logic              wr_stb, rd_stb, odd;
    logic [ADDR_W-2:0] waddr;
    stage_tgt_e        sel;
    logic [DW-1:0]     word_val, rd_val;

    assign wr_stb = cs_i & wr_i;
    assign rd_stb = cs_i & rd_i;
    assign odd    = addr_i[0];
    assign waddr  = addr_i[ADDR_W-1:1];

    // Map the word address onto a writable register, if any.
    always_comb begin
        if (waddr == W_CW1)      sel = STG_CW1;
        else if (waddr == W_CW2) sel = STG_CW2;
        else                     sel = STG_NONE;
    end

    // Control words and byte staging: word writes, low-byte stage, high-byte commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw1_q       <= '0;
            cw2_q       <= '0;
            stage_q     <= '0;
            stage_tgt_q <= STG_NONE;
        end else if (wr_stb) begin
            if (!byte_mode_i) begin
                if (!odd && sel == STG_CW1) cw1_q <= wdata_i;
                if (!odd && sel == STG_CW2) cw2_q <= wdata_i;
            end else if (!odd) begin
                if (sel != STG_NONE) begin
                    stage_q     <= wdata_i[BW-1:0];
                    stage_tgt_q <= sel;
                end
            end else if (sel != STG_NONE) begin
                if (stage_tgt_q == sel && sel == STG_CW1) cw1_q <= {wdata_i[BW-1:0], stage_q};
                if (stage_tgt_q == sel && sel == STG_CW2) cw2_q <= {wdata_i[BW-1:0], stage_q};
                stage_tgt_q <= STG_NONE;
            end
        end
    end

    // Full word of the addressed register.
    always_comb begin
        word_val = '0;
        if (sel == STG_CW1)      word_val = cw1_q;
        else if (sel == STG_CW2) word_val = cw2_q;
        else if (waddr == W_STAT) word_val = {{(DW-NSRC){1'b0}}, status_i};
    end

    // Lane selection for word mode or byte mode.
    always_comb begin
        if (byte_mode_i)
            rd_val = {{BW{1'b0}}, odd ? word_val[DW-1:BW] : word_val[BW-1:0]};
        else
            rd_val = odd ? '0 : word_val;
    end

    // Read data register: captured on each read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_stb) rdata_q <= rd_val;
    end

    assign stat_clr_o = rd_stb && !odd && (waddr == W_STAT);
    assign cw1_o      = cw1_q;
    assign cw2_o      = cw2_q;
    assign rdata_o    = rdata_q;

    // R9: a low-byte write never changes a control word by itself
    p_stage_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && byte_mode_i && !odd) |=> ($stable(cw1_q) && $stable(cw2_q)));

    // R12: read data holds between read strobes
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rdata_q));

    // R8: word-mode odd writes leave both control words untouched
    p_odd_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !byte_mode_i && odd) |=> ($stable(cw1_q) && $stable(cw2_q)));

endmodule

// File: rtl/irqc_status.sv
// Status latch: turns event pulses and per-port direction mismatches into
// sticky status bits, cleared by a status read. A same-cycle event wins
// over the clear. Assumes events are single-cycle pulses.
module irqc_status
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_tgt1_i,
    input  logic            evt_tgt2_i,
    input  logic            evt_tick_i,
    input  logic            evt_idx_i,
    input  logic            evt_ovf1_i,
    input  logic            evt_ovf2_i,
    input  logic            step_i,
    input  logic            step_ccw_i,
    input  logic            dir1_i,
    input  logic            dir2_i,
    input  logic            clr_i,
    output logic [NSRC-1:0] status_o
);

    logic [NSRC-1:0] status_q, set_v;

    // Collect this cycle's set requests, one per source.
    always_comb begin
        set_v          = '0;
        set_v[ST_TGT1] = evt_tgt1_i;
        set_v[ST_TGT2] = evt_tgt2_i;
        set_v[ST_TICK] = evt_tick_i;
        set_v[ST_IDX]  = evt_idx_i;
        set_v[ST_WD1]  = step_i && (step_ccw_i != dir1_i);
        set_v[ST_WD2]  = step_i && (step_ccw_i != dir2_i);
        set_v[ST_OVF1] = evt_ovf1_i;
        set_v[ST_OVF2] = evt_ovf2_i;
    end

    // Sticky status: clear on read, new sets override the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (clr_i ? '0 : status_q) | set_v;
    end

    assign status_o = status_q;

    // R1: reset leaves the status empty
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0));

    // R2: without a clear, no set bit is lost
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R4: an event is recorded even in a clearing cycle
    p_evt_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((status_q & $past(set_v)) == $past(set_v)));

endmodule

// File: rtl/irqc_port.sv
// One interrupt port: ORs the status bits enabled for this port by
// control word 1. PORT selects which enable map is used.
module irqc_port
    import irqc_pkg::*;
#(
    parameter int PORT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] status_i,
    input  logic [DW-1:0]   cw1_i,
    output logic            irq_o
);

    logic [NSRC-1:0] en;

    // Enable map for this port.
    assign en    = port_mask(PORT, cw1_i);
    assign irq_o = |(status_i & en);

    // R7: overflow bits alone never raise the port
    p_ovf_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_i & ~OVF_MASK) == '0) |-> !irq_o);

endmodule

// File: rtl/irqc_top.sv
// Top of the dual-port interrupt controller: register bank, status latch
// and one gating instance per interrupt port.
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode_i,
    input  logic              cs_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic              evt_tgt1_i,
    input  logic              evt_tgt2_i,
    input  logic              evt_tick_i,
    input  logic              evt_idx_i,
    input  logic              evt_ovf1_i,
    input  logic              evt_ovf2_i,
    input  logic              step_i,
    input  logic              step_ccw_i,
    output logic              irq1_o,
    output logic              irq2_o
);

    logic [DW-1:0]    cw1, cw2;
    logic [NSRC-1:0]  status;
    logic             stat_clr;
    logic [NPORT-1:0] irq_v;

    irqc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .byte_mode_i(byte_mode_i),
        .cs_i(cs_i), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .status_i(status), .cw1_o(cw1), .cw2_o(cw2),
        .stat_clr_o(stat_clr), .rdata_o(rdata_o)
    );

    irqc_status u_status (
        .clk(clk), .rst_n(rst_n),
        .evt_tgt1_i(evt_tgt1_i), .evt_tgt2_i(evt_tgt2_i),
        .evt_tick_i(evt_tick_i), .evt_idx_i(evt_idx_i),
        .evt_ovf1_i(evt_ovf1_i), .evt_ovf2_i(evt_ovf2_i),
        .step_i(step_i), .step_ccw_i(step_ccw_i),
        .dir1_i(cw1[CW_DIR1]), .dir2_i(cw1[CW_DIR2]),
        .clr_i(stat_clr), .status_o(status)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        irqc_port #(.PORT(p)) u_port (
            .clk(clk), .rst_n(rst_n), .status_i(status),
            .cw1_i(cw1), .irq_o(irq_v[p])
        );
    end

    assign irq1_o = irq_v[0];
    assign irq2_o = irq_v[1];

    // R1: both ports are quiet in the cycle after reset
    p_irq_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq1_o && !irq2_o));

    // R2 (with R5, R6): a port rises only on a latched cause
    p_irq_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> (!irq1_o && !irq2_o));

    // unused control word 2 bits are storage only
    logic unused_cw2;
    assign unused_cw2 = ^cw2;

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_mode = 1'b0;
    logic        cs = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        e_t1 = 0, e_t2 = 0, e_tk = 0, e_ix = 0, e_o1 = 0, e_o2 = 0;
    logic        step = 0, ccw = 0;
    logic        irq1, irq2;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .byte_mode_i(byte_mode), .cs_i(cs),
        .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .evt_tgt1_i(e_t1), .evt_tgt2_i(e_t2), .evt_tick_i(e_tk),
        .evt_idx_i(e_ix), .evt_ovf1_i(e_o1), .evt_ovf2_i(e_o2),
        .step_i(step), .step_ccw_i(ccw), .irq1_o(irq1), .irq2_o(irq2)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr = 0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); cs = 1; rd = 1; addr = a;
        @(negedge clk); cs = 0; rd = 0; d = rdata;
    endtask

    // id: 0 tgt1, 1 tgt2, 2 tick, 3 index, 4 step ccw, 5 step cw, 6 ovf1, 7 ovf2
    task automatic fire(input int id);
        @(negedge clk);
        case (id)
            0: e_t1 = 1;  1: e_t2 = 1;  2: e_tk = 1;  3: e_ix = 1;
            4: begin step = 1; ccw = 1; end
            5: begin step = 1; ccw = 0; end
            6: e_o1 = 1;  default: e_o2 = 1;
        endcase
        @(negedge clk);
        {e_t1, e_t2, e_tk, e_ix, e_o1, e_o2, step, ccw} = '0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1", "rdata after reset", rdata, 16'h0);
        chk("R1", "irq pair after reset", {14'h0, irq2, irq1}, 16'h0);
        bus_rd(5'h00, v); chk("R1", "cw1 after reset", v, 16'h0);
        bus_rd(5'h02, v); chk("R1", "cw2 after reset", v, 16'h0);
        bus_rd(5'h04, v); chk("R1", "status after reset", v, 16'h0);
    endtask

    task automatic t_word_regs();
        logic [15:0] v;
        bus_wr(5'h00, 16'hA5C2); bus_wr(5'h02, 16'h1234);
        bus_rd(5'h00, v); chk("R8", "cw1 word readback", v, 16'hA5C2);
        bus_rd(5'h02, v); chk("R8", "cw2 word readback", v, 16'h1234);
        bus_wr(5'h01, 16'hFFFF);
        bus_rd(5'h00, v); chk("R8", "odd word write ignored", v, 16'hA5C2);
        bus_rd(5'h03, v); chk("R8", "odd word read zero", v, 16'h0);
        // R12: value holds through idle cycles and a write
        bus_rd(5'h02, v);
        bus_wr(5'h00, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R12", "rdata held", rdata, 16'h1234);
    endtask

    task automatic t_latch();
        logic [15:0] v;
        bus_wr(5'h00, 16'h0000);
        fire(0);
        repeat (2) @(negedge clk);
        bus_rd(5'h04, v); chk("R2", "tgt1 latched", v, 16'h0001);
        bus_rd(5'h04, v); chk("R4", "cleared by read", v, 16'h0000);
        fire(1); fire(2); fire(3);
        bus_rd(5'h04, v); chk("R2", "tgt2/tick/index", v, 16'h000E);
        bus_wr(5'h00, 16'hFFFF);
        fire(6); fire(7);
        chk("R7", "ovf no irq", {14'h0, irq2, irq1}, 16'h0);
        bus_rd(5'h04, v); chk("R2", "ovf bits", v, 16'h00C0);
    endtask

    task automatic t_dir();
        logic [15:0] v;
        bus_wr(5'h00, 16'h1000); // port1 expects cw, port2 expects ccw
        fire(4);
        bus_rd(5'h04, v); chk("R3", "ccw step", v, 16'h0010);
        fire(5);
        bus_rd(5'h04, v); chk("R3", "cw step", v, 16'h0020);
        bus_wr(5'h00, 16'h1002); // both expect ccw
        fire(4);
        bus_rd(5'h04, v); chk("R3", "matching step", v, 16'h0000);
    endtask

    task automatic t_port(input int port, input logic [15:0] cw, input int id, input string tag);
        logic [15:0] v;
        logic [15:0] exp;
        bus_wr(5'h00, cw);
        fire(id);
        exp = (port == 0) ? 16'h0001 : 16'h0002;
        chk(tag, $sformatf("irq pair cw=%h ev=%0d", cw, id), {14'h0, irq2, irq1}, exp);
        bus_rd(5'h04, v);
        chk(tag, "irq drops after clear", {14'h0, irq2, irq1}, 16'h0);
    endtask

    task automatic t_ports();
        t_port(0, 16'h0001, 0, "R5"); t_port(0, 16'h0020, 1, "R5");
        t_port(0, 16'h0004, 2, "R5"); t_port(0, 16'h0010, 3, "R5");
        t_port(0, 16'h0008, 4, "R5");
        t_port(1, 16'h0400, 1, "R6"); t_port(1, 16'h0800, 0, "R6");
        t_port(1, 16'h8000, 2, "R6"); t_port(1, 16'h4000, 3, "R6");
        t_port(1, 16'h2000, 4, "R6");
        bus_wr(5'h00, 16'h0801); // tgt1 on both ports
        fire(1);
        chk("R5", "tgt2 not enabled", {14'h0, irq2, irq1}, 16'h0);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        bus_rd(5'h04, v);
        fire(0);
        @(negedge clk); cs = 1; rd = 1; addr = 5'h04; e_ix = 1;
        @(negedge clk); cs = 0; rd = 0; e_ix = 0;
        chk("R4", "read value excludes new event", rdata, 16'h0001);
        bus_rd(5'h04, v); chk("R4", "new event survives clear", v, 16'h0008);
    endtask

    task automatic t_bytes();
        logic [15:0] v;
        bus_wr(5'h02, 16'h0000);
        byte_mode = 1;
        bus_wr(5'h02, 16'h0034);
        bus_rd(5'h02, v); chk("R9", "low byte only staged", v, 16'h0000);
        bus_wr(5'h03, 16'h0012);
        bus_rd(5'h02, v); chk("R11", "low byte read", v, 16'h0034);
        bus_rd(5'h03, v); chk("R9", "high byte committed", v, 16'h0012);
        bus_wr(5'h03, 16'h0077);
        bus_rd(5'h03, v); chk("R10", "unstaged high ignored", v, 16'h0012);
        bus_wr(5'h00, 16'h0055); bus_wr(5'h03, 16'h0066);
        bus_rd(5'h03, v); chk("R10", "stage for other reg ignored", v, 16'h0012);
        bus_rd(5'h02, v); chk("R10", "cw2 low unchanged", v, 16'h0034);
        fire(0); fire(7);
        bus_rd(5'h05, v); chk("R11", "status high byte", v, 16'h0000);
        bus_rd(5'h04, v); chk("R11", "odd read kept status", v, 16'h0081);
        bus_rd(5'h04, v); chk("R4", "byte read cleared", v, 16'h0000);
        byte_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_word_regs();
        t_latch();
        t_dir();
        t_ports();
        t_same_cycle();
        t_bytes();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule